// File: doc/BRIEF.md
# PCI Read Request Translator

This block sits on the target side of a bridge from PCI to a local bus. It receives one PCI memory read after decode and turns it into a single local-bus read request. It works out whether the read is a single or a burst read, maps the PCI address into the local window, picks the local byte enables and sets the word count of the request.

The classification uses the command code and whether FRAME# and IRDY# were both active on the first clock. The address is mapped by keeping the offset inside a power-of-two BAR window and replacing the bits above it with a local base. A burst never runs past the top of the BAR window, and it is never longer than a configured maximum. A one-entry register holds each request until the local side accepts it. The protocol engine, the data FIFOs and the bus master are outside this block.

Top module: `pci_rd_xlate`

## Requirements
- R1: Command code 4'b1100 (memory read multiple) always gives a burst request (`rq_burst_o` = 1).
- R2: Command code 4'b0110 (memory read) gives a burst request when `frame_act_i` and `irdy_act_i` are both 1. If `frame_act_i` is 0 it gives a single request (`rq_burst_o` = 0).
- R3: For a single request, `rq_addr_o` takes the bits above the window (window size 2^`bar_log2_i` bytes) from `lb_base_i` and the bits inside it from `pci_addr_i`. Bits [1:0] are the index of the lowest asserted bit of `pci_be_i` (bit 0 maps to 00 and bit 3 maps to 11).
- R4: For a single request, `rq_be_o` equals `pci_be_i`, where bit n is byte lane n and is active high. If `pci_be_i` is 0000, then `rq_be_o` is 0000 and address bits [1:0] are 00.
- R5: For a burst request, address bits [1:0] are 00 and `rq_be_o` is 1111, whatever `pci_be_i` holds.
- R6: For a burst, `rq_len_o` is the smaller of MAX_BURST and the number of 32-bit words from the aligned offset to the top of the window. For a single request it is 1.
- R7: Any other command code is taken from the input (`in_ready_o` is high) and produces no request.
- R8: While `rq_valid_o` is 1 and `rq_ready_i` is 0, every request output holds its value and `in_ready_o` is 0.
- R9: `in_ready_o` is 1 when the register is empty or is being drained in the same cycle. A request taken on a clock edge shows on the outputs right after that edge.
- R10: After reset `rq_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | async reset, active low |
| in_valid_i | input | 1 | decoded read offered |
| in_ready_o | output | 1 | read taken this cycle |
| pci_cmd_i | input | 4 | PCI command code |
| pci_addr_i | input | 32 | PCI address |
| pci_be_i | input | 4 | first-phase byte enables, active high |
| frame_act_i | input | 1 | FRAME# active on first clock |
| irdy_act_i | input | 1 | IRDY# active on first clock |
| lb_base_i | input | 32 | local window base |
| bar_log2_i | input | 5 | log2 of BAR size in bytes (2..31) |
| rq_valid_o | output | 1 | local request valid |
| rq_ready_i | input | 1 | local side takes request |
| rq_addr_o | output | 32 | local address |
| rq_be_o | output | 4 | local byte enables |
| rq_burst_o | output | 1 | 1 = burst, 0 = single |
| rq_len_o | output | 5 | word count |

## Verification
Two functions can fall in the same cycle: the local side draining the held request, and a new PCI read being captured. The bench holds a request under backpressure with a second read already waiting. It checks that the first request stays stable and that the input is not ready. It then raises ready for one edge and checks that the second request appears right after that edge, with no empty cycle and no duplicated request. Window-end clipping is tested on the same path, with the window top placed both below and above the maximum length.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;

  // index of lowest active lane, 00 when none
  function automatic logic [1:0] low_lane(input logic [3:0] be);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (be[i]) idx = 2'(i);
    return idx;
  endfunction
endpackage

// File: rtl/pci_rd_classify.sv
module pci_rd_classify
  import pci_rd_pkg::*;
(
  input  logic [3:0] cmd_i,
  input  logic       frame_act_i,
  input  logic       irdy_act_i,
  output logic       is_read_o,
  output logic       burst_o
);
  always_comb begin
    is_read_o = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_RDM);
    burst_o   = (cmd_i == CMD_MEM_RDM) ||
                ((cmd_i == CMD_MEM_RD) && frame_act_i && irdy_act_i);
  end
endmodule

// File: rtl/pci_rd_addr.sv
module pci_rd_addr
  import pci_rd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SZ_W = 5
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [AW-1:0]   base_i,
  input  logic [SZ_W-1:0] log2_i,
  input  logic [3:0]      be_i,
  input  logic            burst_i,
  output logic [AW-1:0]   off_o,
  output logic [AW-1:0]   addr_o,
  output logic [3:0]      be_o
);
  logic [AW:0]   win;
  logic [AW-1:0] mask;
  logic [AW-1:0] mapped;

  always_comb begin
    win    = (AW+1)'(1) << log2_i;
    mask   = win[AW-1:0] - AW'(1);
    off_o  = addr_i & mask;
    mapped = (base_i & ~mask) | off_o;
    if (burst_i) begin
      addr_o = {mapped[AW-1:2], 2'b00};
      be_o   = 4'hf;
    end else begin
      addr_o = {mapped[AW-1:2], low_lane(be_i)};
      be_o   = be_i;
    end
  end
endmodule

// File: rtl/pci_rd_len.sv
module pci_rd_len #(
  parameter int AW        = 32,
  parameter int SZ_W      = 5,
  parameter int MAX_BURST = 16,
  parameter int LEN_W     = 5
) (
  input  logic [AW-1:2]   off_w_i,
  input  logic [SZ_W-1:0] log2_i,
  input  logic            burst_i,
  output logic [LEN_W-1:0] len_o
);
  logic [AW:0] win;
  logic [AW:0] left;

  always_comb begin
    win  = (AW+1)'(1) << log2_i;
    left = (win - {1'b0, off_w_i, 2'b00}) >> 2;
    if (!burst_i)
      len_o = LEN_W'(1);
    else if (left < (AW+1)'(MAX_BURST))
      len_o = left[LEN_W-1:0];
    else
      len_o = LEN_W'(MAX_BURST);
  end
endmodule

// File: rtl/pci_rd_xlate.sv
module pci_rd_xlate #(
  parameter int AW        = 32,
  parameter int MAX_BURST = 16,
  localparam int SZ_W     = $clog2(AW),
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [3:0]       pci_cmd_i,
  input  logic [AW-1:0]    pci_addr_i,
  input  logic [3:0]       pci_be_i,
  input  logic             frame_act_i,
  input  logic             irdy_act_i,
  input  logic [AW-1:0]    lb_base_i,
  input  logic [SZ_W-1:0]  bar_log2_i,
  output logic             rq_valid_o,
  input  logic             rq_ready_i,
  output logic [AW-1:0]    rq_addr_o,
  output logic [3:0]       rq_be_o,
  output logic             rq_burst_o,
  output logic [LEN_W-1:0] rq_len_o
);
  logic             is_read, burst;
  logic [AW-1:0]    off, n_addr;
  logic [3:0]       n_be;
  logic [LEN_W-1:0] n_len;

  pci_rd_classify u_cls (
    .cmd_i(pci_cmd_i), .frame_act_i(frame_act_i), .irdy_act_i(irdy_act_i),
    .is_read_o(is_read), .burst_o(burst)
  );

  pci_rd_addr #(.AW(AW), .SZ_W(SZ_W)) u_addr (
    .addr_i(pci_addr_i), .base_i(lb_base_i), .log2_i(bar_log2_i),
    .be_i(pci_be_i), .burst_i(burst), .off_o(off), .addr_o(n_addr), .be_o(n_be)
  );

  pci_rd_len #(.AW(AW), .SZ_W(SZ_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_len (
    .off_w_i(off[AW-1:2]), .log2_i(bar_log2_i), .burst_i(burst), .len_o(n_len)
  );

  assign in_ready_o = !rq_valid_o || rq_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_valid_o <= 1'b0;
      rq_addr_o  <= '0;
      rq_be_o    <= '0;
      rq_burst_o <= 1'b0;
      rq_len_o   <= '0;
    end else if (in_ready_o) begin
      rq_valid_o <= in_valid_i && is_read;
      if (in_valid_i && is_read) begin
        rq_addr_o  <= n_addr;
        rq_be_o    <= n_be;
        rq_burst_o <= burst;
        rq_len_o   <= n_len;
      end
    end
  end
endmodule

module pci_rd_xlate_chk #(
  parameter int AW = 32,
  parameter int MAX_BURST = 16,
  parameter int LEN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [3:0]       pci_cmd_i,
  input logic             rq_valid_o,
  input logic             rq_ready_i,
  input logic [AW-1:0]    rq_addr_o,
  input logic [3:0]       rq_be_o,
  input logic             rq_burst_o,
  input logic [LEN_W-1:0] rq_len_o
);
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rq_valid_o && !rq_ready_i |=> rq_valid_o && $stable(rq_addr_o) &&
      $stable(rq_be_o) && $stable(rq_burst_o) && $stable(rq_len_o));
  // R8
  no_take_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rq_valid_o && !rq_ready_i |-> !in_ready_o);
  // R5
  burst_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rq_valid_o && rq_burst_o |-> rq_be_o == 4'hf && rq_addr_o[1:0] == 2'b00);
  // R6
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rq_valid_o && rq_burst_o |-> rq_len_o != '0 && rq_len_o <= LEN_W'(MAX_BURST));
  // R6
  single_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rq_valid_o && !rq_burst_o |-> rq_len_o == LEN_W'(1));
  // R9
  take_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (pci_cmd_i == 4'b0110 || pci_cmd_i == 4'b1100)
      |=> rq_valid_o);
  // R7
  drop_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && pci_cmd_i != 4'b0110 && pci_cmd_i != 4'b1100
      |=> !rq_valid_o);
endmodule

bind pci_rd_xlate pci_rd_xlate_chk #(.AW(AW), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .pci_cmd_i(pci_cmd_i), .rq_valid_o(rq_valid_o), .rq_ready_i(rq_ready_i),
  .rq_addr_o(rq_addr_o), .rq_be_o(rq_be_o), .rq_burst_o(rq_burst_o), .rq_len_o(rq_len_o)
);

// File: tb/pci_rd_xlate_tb.sv
module pci_rd_xlate_tb;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [3:0]  cmd = 0, be = 0;
  logic [31:0] addr = 0, base = 32'h8000_0000;
  logic        frame = 0, irdy = 0;
  logic [4:0]  lg = 5'd12;
  logic        rq_valid, rq_ready = 1, rq_burst;
  logic [31:0] rq_addr;
  logic [3:0]  rq_be;
  logic [4:0]  rq_len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_rd_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .pci_cmd_i(cmd), .pci_addr_i(addr), .pci_be_i(be), .frame_act_i(frame),
    .irdy_act_i(irdy), .lb_base_i(base), .bar_log2_i(lg), .rq_valid_o(rq_valid),
    .rq_ready_i(rq_ready), .rq_addr_o(rq_addr), .rq_be_o(rq_be),
    .rq_burst_o(rq_burst), .rq_len_o(rq_len)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // expected request from the requirements
  task automatic expect_req(string req, logic b, logic [31:0] a, logic [3:0] e, int l);
    chk({req, " valid"}, 64'(rq_valid), 64'(1));
    chk({req, " burst"}, 64'(rq_burst), 64'(b));
    chk({req, " addr"}, 64'(rq_addr), 64'(a));
    chk({req, " be"}, 64'(rq_be), 64'(e));
    chk({req, " len"}, 64'(rq_len), 64'(l));
  endtask

  task automatic send(logic [3:0] c, logic [31:0] a, logic [3:0] e, logic f, logic i);
    cmd = c; addr = a; be = e; frame = f; irdy = i; in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    chk("R10 valid", 64'(rq_valid), 0);
    chk("R10 ready", 64'(in_ready), 1);
  endtask

  task automatic t_mrm;
    send(4'b1100, 32'h1234_5103, 4'b0010, 0, 0);
    expect_req("R1 R5", 1, 32'h8000_0100, 4'hf, 16);
  endtask

  task automatic t_read_burst;
    send(4'b0110, 32'h0000_0204, 4'b1000, 1, 1);
    expect_req("R2 burst", 1, 32'h8000_0204, 4'hf, 16);
  endtask

  task automatic t_single;
    send(4'b0110, 32'hFFFF_F340, 4'b1100, 0, 1);
    expect_req("R2 R3 R4 single", 0, 32'h8000_0342, 4'b1100, 1);
    send(4'b0110, 32'h0000_0010, 4'b1000, 0, 1);
    expect_req("R3 lane3", 0, 32'h8000_0013, 4'b1000, 1);
    send(4'b0110, 32'h0000_0023, 4'b0000, 0, 1);
    expect_req("R4 none", 0, 32'h8000_0020, 4'b0000, 1);
  endtask

  task automatic t_clip;
    send(4'b1100, 32'h5555_5FF8, 4'b0001, 1, 1);
    expect_req("R6 clip2", 1, 32'h8000_0FF8, 4'hf, 2);
    send(4'b1100, 32'h5555_5FC3, 4'b0001, 1, 1);
    expect_req("R6 exact16", 1, 32'h8000_0FC0, 4'hf, 16);
    lg = 5'd4;
    send(4'b1100, 32'h0000_0004, 4'b0001, 1, 1);
    expect_req("R6 small window", 1, 32'h8000_0004, 4'hf, 3);
    lg = 5'd12;
  endtask

  task automatic t_other;
    send(4'b0111, 32'h0000_0100, 4'hf, 1, 1);
    chk("R7 no request", 64'(rq_valid), 0);
    chk("R7 ready", 64'(in_ready), 1);
  endtask

  task automatic t_backpressure;
    rq_ready = 0;
    send(4'b0110, 32'h0000_0088, 4'b0100, 0, 1);
    expect_req("R8 held A", 0, 32'h8000_008A, 4'b0100, 1);
    cmd = 4'b1100; addr = 32'h0000_0400; be = 4'b0001; frame = 1; irdy = 1;
    in_valid = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 not ready", 64'(in_ready), 0);
      expect_req("R8 stable A", 0, 32'h8000_008A, 4'b0100, 1);
    end
    rq_ready = 1;
    #1 chk("R9 ready on drain", 64'(in_ready), 1);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    expect_req("R9 back-to-back B", 1, 32'h8000_0400, 4'hf, 16);
    @(negedge clk);
    chk("R9 drained", 64'(rq_valid), 0);
  endtask

  initial begin
    #1 t_reset;
    #10 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_mrm;
    t_read_burst;
    t_single;
    t_clip;
    t_other;
    t_backpressure;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule